// File: doc/BRIEF.md
# Transactional write buffer cache

This block is a small, fully associative side cache that keeps one core's transactional data apart from its regular cache. The core sends it transactional loads, exclusive-intent loads and stores, and three transaction commands: commit, abort and validate. A store does not overwrite the line in place. It keeps a pair of entries for the address: one holds the value as it was before the transaction, the other holds the speculative value. Commit keeps the speculative copy and abort keeps the old one.

A snoop port reports the remote reads and writes of other processors. A remote access that collides with the transaction's read or write footprint clears a status flag. Once the flag is clear, loads return a fixed filler word and stores are dropped until the next command resolves the transaction. Speculative data never leaves the block through the snoop port. A miss is served by a single-beat fill handshake. The fill asks for exclusive ownership when a write is expected.

Top module: `txn_cache`

## Requirements
- R1: The block holds 64 fully associative lines of 64 bits. A load miss raises `fill_req` once and returns `fill_data`. A repeat load of the same address returns the data with no new fill. `fill_excl` is 0 for a plain load (op 0) and 1 for an exclusive load (op 1) or a store (op 2).
- R2: After a store (op 2), the core's own loads of that address return the new value. A snoop read of the address returns the value from before the transaction.
- R3: A commit (op 3) with no conflict returns `done_ok`=1. After it, snoop reads and loads return the stored value and no line remains in a paired state.
- R4: An abort (op 4) returns `done_ok`=0. After it, loads and snoop reads return the value from before the transaction.
- R5: Line replacement prefers an empty line, then a plain valid line, then an original-value copy. A speculative copy is never replaced during a live transaction. When no second line can be found for a store's pair, the flag is cleared and the store is dropped.
- R6: A snoop write hitting a line read or written in the transaction clears `tx_ok` at the next clock edge. So does a snoop read hitting a written line.
- R7: While `tx_ok` is 0, loads return the filler word (all zeros) and issue no fill, and stores issue no fill.
- R8: A commit while the flag is clear returns `done_ok`=0 and discards the speculative data. A conflicting snoop in the same cycle as the commit also makes the commit fail.
- R9: Validate (op 5) returns the flag in `done_ok`. When the flag is 0, validate discards the speculative data as abort does and sets the flag back to 1. When the flag is 1, the transaction continues.
- R10: `done` is a one-cycle pulse that follows the command's acceptance edge. A load or store that hits answers with `resp_valid` one cycle after acceptance.
- R11: After reset, all lines are empty, `tx_ok`=1, `req_ready`=1, and `done`, `resp_valid` and `snp_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | 0 load, 1 exclusive load, 2 store, 3 commit, 4 abort, 5 validate |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W | Store data |
| resp_valid | output | 1 | Load/store answer pulse |
| resp_rdata | output | DATA_W | Load data |
| done | output | 1 | Command completion pulse |
| done_ok | output | 1 | Command result |
| tx_ok | output | 1 | Transaction status flag |
| fill_req | output | 1 | Fill request |
| fill_excl | output | 1 | Fill wants exclusive ownership |
| fill_addr | output | ADDR_W | Fill line address |
| fill_ack | input | 1 | Fill response strobe |
| fill_data | input | DATA_W | Fill response data |
| snp_valid | input | 1 | Remote access strobe |
| snp_write | input | 1 | Remote access is a write |
| snp_addr | input | ADDR_W | Remote access line address |
| snp_hit | output | 1 | Visible copy present |
| snp_data | output | DATA_W | Visible copy data |

## Verification
Two events can fall in the same cycle: a remote snoop that collides with the read footprint, and the acceptance of a commit. The bench drives both on the same negative edge, with the snoop write aimed at a line the transaction has read. The commit must then report failure while the flag returns to 1. In a control run, a snoop to an address the block does not hold arrives in the same cycle as a commit, and that commit must succeed.

// File: rtl/txn_cache_pkg.sv
// Shared encodings for the transactional write buffer cache.
// Assumes: a 2-bit line state and a 3-bit request opcode.
package txn_cache_pkg;
    typedef enum logic [1:0] {
        TS_EMPTY   = 2'd0,
        TS_NORMAL  = 2'd1,
        TS_XCOMMIT = 2'd2,
        TS_XABORT  = 2'd3
    } tstate_e;

    typedef enum logic [2:0] {
        OP_LOAD     = 3'd0,
        OP_LOADX    = 3'd1,
        OP_STORE    = 3'd2,
        OP_COMMIT   = 3'd3,
        OP_ABORT    = 3'd4,
        OP_VALIDATE = 3'd5
    } op_e;
endpackage

// File: rtl/txn_cache_match.sv
// Address compare for the whole line array.
// The core-side lookup finds a speculative copy or a plain copy.
// The snoop side finds the visible copy and decides whether a remote access
// collides with the transaction footprint.
// Assumes: at most one line of each state holds a given address.
module txn_cache_match
    import txn_cache_pkg::*;
#(
    parameter int LINES  = 64,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    parameter int IDX_W  = 6
) (
    input  logic [LINES-1:0][1:0]        st,
    input  logic [LINES-1:0][ADDR_W-1:0] tags,
    input  logic [LINES-1:0][DATA_W-1:0] lines,
    input  logic [LINES-1:0]             rd_set,
    input  logic [ADDR_W-1:0]            look_addr,
    input  logic                         snp_valid,
    input  logic                         snp_write,
    input  logic [ADDR_W-1:0]            snp_addr,
    output logic                         hit_xab,
    output logic [IDX_W-1:0]             idx_xab,
    output logic                         hit_norm,
    output logic [IDX_W-1:0]             idx_norm,
    output logic [LINES-1:0]             norm_mask,
    output logic                         snp_hit,
    output logic [DATA_W-1:0]            snp_data,
    output logic                         conflict
);
    logic [LINES-1:0] m_xab, m_norm, m_vis, m_cf;
    logic [IDX_W-1:0] vis_idx;

    // Per-line compares for both lookup ports
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic look_eq, snp_eq, spec;
        assign look_eq   = (tags[g] == look_addr);
        assign snp_eq    = (tags[g] == snp_addr);
        assign spec      = (st[g] == TS_XCOMMIT) || (st[g] == TS_XABORT);
        assign m_xab[g]  = look_eq && (st[g] == TS_XABORT);
        assign m_norm[g] = look_eq && (st[g] == TS_NORMAL);
        assign m_vis[g]  = snp_eq && ((st[g] == TS_NORMAL) || (st[g] == TS_XCOMMIT));
        assign m_cf[g]   = snp_eq && (snp_write ? (rd_set[g] || spec) : spec);
    end

    // Encode the lowest matching line of each kind
    always_comb begin
        idx_xab  = '0;
        idx_norm = '0;
        vis_idx  = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (m_xab[i])  idx_xab  = IDX_W'(i);
            if (m_norm[i]) idx_norm = IDX_W'(i);
            if (m_vis[i])  vis_idx  = IDX_W'(i);
        end
        hit_xab             = |m_xab;
        hit_norm            = |m_norm;
        norm_mask           = '0;
        norm_mask[idx_norm] = hit_norm;
        snp_hit             = snp_valid && (|m_vis);
        snp_data            = snp_hit ? lines[vis_idx] : '0;
        conflict            = snp_valid && (|m_cf);
    end
endmodule

// File: rtl/txn_cache_victim.sv
// Replacement picker. An empty line wins over a plain line, and a plain line
// wins over an original-value copy. A speculative copy is never offered.
// Lines in the exclude mask are skipped.
// Assumes: the lowest index wins within a class.
module txn_cache_victim
    import txn_cache_pkg::*;
#(
    parameter int LINES = 64,
    parameter int IDX_W = 6
) (
    input  logic [LINES-1:0][1:0] st,
    input  logic [LINES-1:0]      excl,
    output logic                  vic_ok,
    output logic [IDX_W-1:0]      vic_idx
);
    logic [LINES-1:0] c_emp, c_nrm, c_xc;
    logic [IDX_W-1:0] i_emp, i_nrm, i_xc;

    // Classify each line by replacement preference
    for (genvar g = 0; g < LINES; g++) begin : g_cls
        assign c_emp[g] = !excl[g] && (st[g] == TS_EMPTY);
        assign c_nrm[g] = !excl[g] && (st[g] == TS_NORMAL);
        assign c_xc[g]  = !excl[g] && (st[g] == TS_XCOMMIT);
    end

    // Lowest index per class, then the class order
    always_comb begin
        i_emp = '0;
        i_nrm = '0;
        i_xc  = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (c_emp[i]) i_emp = IDX_W'(i);
            if (c_nrm[i]) i_nrm = IDX_W'(i);
            if (c_xc[i])  i_xc  = IDX_W'(i);
        end
        vic_ok = (|c_emp) || (|c_nrm) || (|c_xc);
        if (|c_emp)      vic_idx = i_emp;
        else if (|c_nrm) vic_idx = i_nrm;
        else             vic_idx = i_xc;
    end
endmodule

// File: rtl/txn_cache.sv
// Transactional write buffer cache, top level.
// It serves transactional loads and stores and keeps an original/speculative
// pair of lines per written address. Commit, abort and validate resolve the
// pairs in a single cycle, and a snoop port flags conflicting remote accesses.
// Assumes: one request at a time (req_ready), a single-beat fill, and a snoop
// answer that is combinational in the cycle of the access.
module txn_cache
    import txn_cache_pkg::*;
#(
    parameter int                 LINES      = 64,
    parameter int                 ADDR_W     = 16,
    parameter int                 DATA_W     = 64,
    parameter logic [DATA_W-1:0]  DUMMY_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              done,
    output logic              done_ok,
    output logic              tx_ok,
    output logic              fill_req,
    output logic              fill_excl,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_ack,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_hit,
    output logic [DATA_W-1:0] snp_data
);
    localparam int IDX_W = $clog2(LINES);

    typedef enum logic [1:0] {S_IDLE, S_FILL, S_PAIR} fsm_e;

    fsm_e                         state;
    logic [LINES-1:0][1:0]        st_q;
    logic [LINES-1:0][ADDR_W-1:0] tag_q;
    logic [LINES-1:0][DATA_W-1:0] line_q;
    logic [LINES-1:0]             rd_q;
    logic [ADDR_W-1:0]            cur_addr;
    logic [DATA_W-1:0]            cur_data;
    logic [2:0]                   cur_op;

    logic [ADDR_W-1:0] look_addr;
    logic [DATA_W-1:0] wr_word;
    logic              hit_xab, hit_norm, conflict, vic_ok;
    logic [IDX_W-1:0]  idx_xab, idx_norm, vic_idx;
    logic [LINES-1:0]  norm_mask;
    logic              acc, is_cmd, cmd_acc, tx_eff, resolve, keep_new, pair_go, store_hit;

    // Request decode and the pair-creation condition
    always_comb begin
        req_ready = (state == S_IDLE);
        acc       = req_valid && req_ready;
        is_cmd    = (req_op == OP_COMMIT) || (req_op == OP_ABORT) || (req_op == OP_VALIDATE);
        cmd_acc   = acc && is_cmd;
        tx_eff    = tx_ok && !conflict;
        keep_new  = (req_op == OP_COMMIT) && tx_eff;
        resolve   = cmd_acc && ((req_op != OP_VALIDATE) || !tx_eff);
        look_addr = (state == S_IDLE) ? req_addr : cur_addr;
        wr_word   = (state == S_IDLE) ? req_wdata : cur_data;
        store_hit = (state == S_IDLE) ? (acc && (req_op == OP_STORE) && !hit_xab)
                                      : (state == S_PAIR);
        pair_go   = store_hit && tx_ok && hit_norm && vic_ok;
        fill_req  = (state == S_FILL);
        fill_addr = cur_addr;
        fill_excl = (cur_op != OP_LOAD);
    end

    txn_cache_match #(
        .LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_match (
        .st(st_q), .tags(tag_q), .lines(line_q), .rd_set(rd_q),
        .look_addr(look_addr), .snp_valid(snp_valid), .snp_write(snp_write),
        .snp_addr(snp_addr), .hit_xab(hit_xab), .idx_xab(idx_xab),
        .hit_norm(hit_norm), .idx_norm(idx_norm), .norm_mask(norm_mask),
        .snp_hit(snp_hit), .snp_data(snp_data), .conflict(conflict)
    );

    txn_cache_victim #(.LINES(LINES), .IDX_W(IDX_W)) u_victim (
        .st(st_q), .excl(norm_mask), .vic_ok(vic_ok), .vic_idx(vic_idx)
    );

    // Request sequencing, line state updates and the transaction flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            st_q       <= '0;
            tag_q      <= '0;
            line_q     <= '0;
            rd_q       <= '0;
            cur_addr   <= '0;
            cur_data   <= '0;
            cur_op     <= '0;
            tx_ok      <= 1'b1;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            done       <= 1'b0;
            done_ok    <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            done       <= 1'b0;
            if (conflict) tx_ok <= 1'b0;
            unique case (state)
                S_IDLE: if (acc) begin
                    cur_addr <= req_addr;
                    cur_data <= req_wdata;
                    cur_op   <= req_op;
                    case (req_op)
                        OP_LOAD, OP_LOADX: begin
                            if (!tx_ok) begin
                                resp_valid <= 1'b1;
                                resp_rdata <= DUMMY_WORD;
                            end else if (hit_xab || hit_norm) begin
                                resp_valid <= 1'b1;
                                resp_rdata <= hit_xab ? line_q[idx_xab] : line_q[idx_norm];
                                rd_q[hit_xab ? idx_xab : idx_norm] <= 1'b1;
                            end else if (vic_ok) begin
                                state <= S_FILL;
                            end else begin
                                tx_ok      <= 1'b0;
                                resp_valid <= 1'b1;
                                resp_rdata <= DUMMY_WORD;
                            end
                        end
                        OP_STORE: begin
                            if (tx_ok && hit_xab) begin
                                line_q[idx_xab] <= req_wdata;
                                resp_valid      <= 1'b1;
                            end else if (tx_ok && !hit_norm && vic_ok) begin
                                state <= S_FILL;
                            end else begin
                                if (!pair_go) tx_ok <= 1'b0;
                                resp_valid <= 1'b1;
                            end
                        end
                        OP_COMMIT, OP_ABORT, OP_VALIDATE: begin
                            done    <= 1'b1;
                            done_ok <= (req_op != OP_ABORT) && tx_eff;
                            tx_ok   <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                S_FILL: if (fill_ack) begin
                    st_q[vic_idx]   <= TS_NORMAL;
                    tag_q[vic_idx]  <= cur_addr;
                    line_q[vic_idx] <= fill_data;
                    rd_q[vic_idx]   <= (cur_op != OP_STORE);
                    if (cur_op == OP_STORE) begin
                        state <= S_PAIR;
                    end else begin
                        state      <= S_IDLE;
                        resp_valid <= 1'b1;
                        resp_rdata <= fill_data;
                    end
                end
                S_PAIR: begin
                    if (!pair_go) tx_ok <= 1'b0;
                    resp_valid <= 1'b1;
                    state      <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
            // Pair creation: the plain copy keeps the original, a new line takes the write
            if (pair_go) begin
                st_q[idx_norm]  <= TS_XCOMMIT;
                st_q[vic_idx]   <= TS_XABORT;
                tag_q[vic_idx]  <= look_addr;
                line_q[vic_idx] <= wr_word;
                rd_q[vic_idx]   <= 1'b0;
            end
            // Resolution: keep one copy of each pair and clear the footprint
            if (resolve) begin
                rd_q <= '0;
                for (int i = 0; i < LINES; i++) begin
                    if (st_q[i] == TS_XCOMMIT) st_q[i] <= keep_new ? TS_EMPTY : TS_NORMAL;
                    if (st_q[i] == TS_XABORT)  st_q[i] <= keep_new ? TS_NORMAL : TS_EMPTY;
                end
            end
        end
    end

    logic [LINES-1:0] spec_lines;
    always_comb begin
        for (int i = 0; i < LINES; i++) spec_lines[i] = st_q[i][1];
    end

    for (genvar g = 0; g < LINES; g++) begin : g_hold
        AST_XABORT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] == TS_XABORT && !resolve) |=> (st_q[g] == TS_XABORT)); // R5
    end
    AST_CONFLICT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && !cmd_acc) |=> !tx_ok); // R6
    AST_NO_FILL_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_req) |-> $past(tx_ok)); // R7
    AST_DONE_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_acc)); // R10
    AST_COMMIT_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ok && $past(req_op) == OP_COMMIT) |-> ($countones(spec_lines) == 0)); // R3
    AST_DISCARD_RESOLVED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ok) |-> ($countones(spec_lines) == 0)); // R8
endmodule

// File: tb/txn_cache_bench.sv
`timescale 1ns/1ps
module txn_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [15:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        resp_valid;
    logic [63:0] resp_rdata;
    logic        done, done_ok, tx_ok;
    logic        fill_req, fill_excl;
    logic [15:0] fill_addr;
    logic        fill_ack = 1'b0;
    logic [63:0] fill_data = '0;
    logic        snp_valid = 1'b0;
    logic        snp_write = 1'b0;
    logic [15:0] snp_addr = '0;
    logic        snp_hit;
    logic [63:0] snp_data;

    int checks = 0;
    int fails = 0;
    int fill_cnt = 0;
    logic last_excl = 1'b0;

    always #2.5 clk = ~clk;

    txn_cache u_txn_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .done(done),
        .done_ok(done_ok), .tx_ok(tx_ok), .fill_req(fill_req),
        .fill_excl(fill_excl), .fill_addr(fill_addr), .fill_ack(fill_ack),
        .fill_data(fill_data), .snp_valid(snp_valid), .snp_write(snp_write),
        .snp_addr(snp_addr), .snp_hit(snp_hit), .snp_data(snp_data)
    );

    function automatic logic [63:0] memfn(input logic [15:0] a);
        return {16'hC0DE, a, a ^ 16'h5A5A, ~a};
    endfunction

    function automatic logic [63:0] wfn(input logic [15:0] a);
        return {16'hBEEF, a, 32'h1234_5678};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Fill responder: answers each request two negedges later
    initial begin
        forever begin
            @(negedge clk);
            if (fill_req) begin
                fill_cnt++;
                last_excl = fill_excl;
                @(negedge clk);
                fill_ack  = 1'b1;
                fill_data = memfn(fill_addr);
                @(negedge clk);
                fill_ack = 1'b0;
            end
        end
    end

    task automatic do_op(input logic [2:0] op, input logic [15:0] a, input logic [63:0] wd,
                         output logic [63:0] rd, output logic ok, output int lat);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!(resp_valid || done) && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        rd = resp_rdata;
        ok = done_ok;
    endtask

    task automatic snoop(input logic w, input logic [15:0] a, output logic hit, output logic [63:0] d);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_write = w;
        snp_addr  = a;
        #1;
        hit = snp_hit;
        d   = snp_data;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic h;
        logic [63:0] d;
        chk("R11 tx_ok", tx_ok, 1);
        chk("R11 req_ready", req_ready, 1);
        chk("R11 done", done, 0);
        chk("R11 resp_valid", resp_valid, 0);
        snoop(1'b0, 16'h0010, h, d);
        chk("R11 snoop miss", h, 0);
    endtask

    task automatic t_load();
        logic [63:0] rd;
        logic ok;
        int lat, fc;
        fc = fill_cnt;
        do_op(3'd0, 16'h0010, '0, rd, ok, lat);
        chk("R1 miss data", rd, memfn(16'h0010));
        chk("R1 one fill", fill_cnt, fc + 1);
        chk("R1 plain fill not exclusive", last_excl, 0);
        do_op(3'd0, 16'h0010, '0, rd, ok, lat);
        chk("R1 hit data", rd, memfn(16'h0010));
        chk("R1 hit no fill", fill_cnt, fc + 1);
        chk("R10 hit latency", lat, 0);
        do_op(3'd1, 16'h0020, '0, rd, ok, lat);
        chk("R1 exclusive load data", rd, memfn(16'h0020));
        chk("R1 exclusive fill", last_excl, 1);
        do_op(3'd3, '0, '0, rd, ok, lat);
        chk("R3 read-only commit", ok, 1);
        chk("R10 done latency", lat, 0);
    endtask

    task automatic t_store_snoop();
        logic [63:0] rd, d;
        logic ok, h;
        int lat;
        do_op(3'd2, 16'h0030, wfn(16'h0030), rd, ok, lat);
        chk("R1 store fill exclusive", last_excl, 1);
        do_op(3'd0, 16'h0030, '0, rd, ok, lat);
        chk("R2 own load sees new", rd, wfn(16'h0030));
        snoop(1'b0, 16'h0030, h, d);
        chk("R2 snoop hit", h, 1);
        chk("R2 snoop sees original", d, memfn(16'h0030));
        chk("R6 remote read of written line", tx_ok, 0);
        do_op(3'd4, '0, '0, rd, ok, lat);
        chk("R9 flag restored", tx_ok, 1);
    endtask

    task automatic t_commit_abort();
        logic [63:0] rd, d;
        logic ok, h;
        int lat;
        do_op(3'd2, 16'h0040, wfn(16'h0040), rd, ok, lat);
        do_op(3'd3, '0, '0, rd, ok, lat);
        chk("R3 commit ok", ok, 1);
        snoop(1'b0, 16'h0040, h, d);
        chk("R3 snoop sees committed", d, wfn(16'h0040));
        do_op(3'd0, 16'h0040, '0, rd, ok, lat);
        chk("R3 load sees committed", rd, wfn(16'h0040));
        do_op(3'd3, '0, '0, rd, ok, lat);
        do_op(3'd2, 16'h0040, 64'h0123_4567_89AB_CDEF, rd, ok, lat);
        do_op(3'd4, '0, '0, rd, ok, lat);
        chk("R4 abort result", ok, 0);
        do_op(3'd0, 16'h0040, '0, rd, ok, lat);
        chk("R4 load sees original", rd, wfn(16'h0040));
        snoop(1'b0, 16'h0040, h, d);
        chk("R4 snoop sees original", d, wfn(16'h0040));
        do_op(3'd3, '0, '0, rd, ok, lat);
    endtask

    task automatic t_conflict();
        logic [63:0] rd, d;
        logic ok, h;
        int lat, fc;
        do_op(3'd0, 16'h0050, '0, rd, ok, lat);
        do_op(3'd2, 16'h0060, wfn(16'h0060), rd, ok, lat);
        chk("R6 flag before", tx_ok, 1);
        snoop(1'b1, 16'h0050, h, d);
        chk("R6 remote write of read line", tx_ok, 0);
        fc = fill_cnt;
        do_op(3'd0, 16'h0070, '0, rd, ok, lat);
        chk("R7 dummy load", rd, 64'h0);
        do_op(3'd2, 16'h0080, wfn(16'h0080), rd, ok, lat);
        chk("R7 no fills", fill_cnt, fc);
        do_op(3'd3, '0, '0, rd, ok, lat);
        chk("R8 commit fails", ok, 0);
        do_op(3'd0, 16'h0060, '0, rd, ok, lat);
        chk("R8 discarded store", rd, memfn(16'h0060));
        chk("R8 flag restored", tx_ok, 1);
        do_op(3'd3, '0, '0, rd, ok, lat);
    endtask

    task automatic t_validate();
        logic [63:0] rd, d;
        logic ok, h;
        int lat;
        do_op(3'd2, 16'h0090, wfn(16'h0090), rd, ok, lat);
        do_op(3'd5, '0, '0, rd, ok, lat);
        chk("R9 validate true", ok, 1);
        do_op(3'd0, 16'h0090, '0, rd, ok, lat);
        chk("R9 transaction lives on", rd, wfn(16'h0090));
        snoop(1'b1, 16'h0090, h, d);
        do_op(3'd5, '0, '0, rd, ok, lat);
        chk("R9 validate false", ok, 0);
        chk("R9 flag restored", tx_ok, 1);
        do_op(3'd0, 16'h0090, '0, rd, ok, lat);
        chk("R9 discarded store", rd, memfn(16'h0090));
        do_op(3'd3, '0, '0, rd, ok, lat);
    endtask

    task automatic t_same_cycle();
        logic [63:0] rd;
        logic ok;
        int lat;
        do_op(3'd0, 16'h00A0, '0, rd, ok, lat);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd3; snp_valid = 1'b1; snp_write = 1'b1; snp_addr = 16'h00A0;
        @(negedge clk);
        req_valid = 1'b0; snp_valid = 1'b0;
        chk("R8 same-cycle done", done, 1);
        chk("R8 same-cycle conflict fails commit", done_ok, 0);
        do_op(3'd0, 16'h00A0, '0, rd, ok, lat);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd3; snp_valid = 1'b1; snp_write = 1'b1; snp_addr = 16'h00B0;
        @(negedge clk);
        req_valid = 1'b0; snp_valid = 1'b0;
        chk("R8 unrelated snoop commit ok", done_ok, 1);
    endtask

    task automatic t_capacity();
        logic [63:0] rd;
        logic ok;
        int lat, drops;
        drops = 0;
        for (int i = 0; i < 63; i++) begin
            do_op(3'd2, 16'(16'h0100 + i), wfn(16'(16'h0100 + i)), rd, ok, lat);
            if (!tx_ok) drops++;
        end
        chk("R5 63 pairs fit", drops, 0);
        do_op(3'd0, 16'h0100, '0, rd, ok, lat);
        chk("R5 oldest speculative copy kept", rd, wfn(16'h0100));
        do_op(3'd2, 16'h013F, wfn(16'h013F), rd, ok, lat);
        chk("R5 no victim clears flag", tx_ok, 0);
        do_op(3'd3, '0, '0, rd, ok, lat);
        chk("R8 overflowed commit fails", ok, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_store_snoop();
        t_commit_abort();
        t_conflict();
        t_validate();
        t_same_cycle();
        t_capacity();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule